// File: doc/BRIEF.md
# SPI NOR Sector Command Engine

This block runs read, program and erase operations on a serial NOR flash. The host side works in 512-byte logical sectors. A command (operation, first sector, sector count) is handed over through a valid/ready handshake. The engine then produces every serial opcode, the 4-byte address, the data phase and the status polling by itself. Program data comes in on a byte stream with valid/ready, and read data goes out on a byte stream with valid/ready. A busy level and a one-cycle done pulse mark the progress of each command.

The serial side runs in mode 0. SCK idles low, bits go out most significant first, MISO is sampled on the rising SCK edge, and SCK runs at half the system clock. Program and erase batches are wrapped in write-enable and write-disable frames. After every program or erase frame, the flash status is polled until its in-progress bit clears. Erase walks the sector range in 256 KB steps, so the caller is expected to align erase ranges to erase blocks.

Top module: `nor_sector_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, busy, done and rd_valid are 0, and cmd_ready is 1.
- R2: Every opcode that carries an address is followed by the 4-byte byte address sector*512, most significant byte first. SCK toggles only while spi_cs_n is low, and bytes are sent MSB first in mode 0.
- R3: A read (cmd_op 0) is one chip-select frame. The frame holds opcode 0x13, the address, and then count*512 data bytes, with 0xFF sent on MOSI during the data bytes.
- R4: Exactly count*512 bytes leave on rd_data, in address order. Bytes shifted in during the opcode and address phase are never presented.
- R5: While rd_valid is high and rd_ready is low, rd_data holds, no byte is lost, chip select stays low, and at most the one byte already in flight is clocked.
- R6: A program (cmd_op 1) starts with opcode 0x06 in a frame of its own. It then sends one frame per sector, made of opcode 0x12, the address and exactly 512 bytes taken in order from the write stream.
- R7: An erase (cmd_op 2) starts with a 0x06 frame. It then sends frames of opcode 0xDC with the addresses start*512 + k*262144, for every k whose address is below (start+count)*512.
- R8: After each program or erase frame, the engine sends 2-byte status frames (opcode 0x05, then 0xFF). It repeats them as long as bit 0 of the second received byte is 1.
- R9: A program or erase batch ends with opcode 0x04 in a frame of its own.
- R10: done is high for exactly one cycle after the last frame has ended, and busy is low in that cycle. cmd_ready is low while busy, and a command offered then has no effect.
- R11: A command with count 0, or with cmd_op 3, produces no frame and raises done two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_op | input | 2 | 0 read, 1 program, 2 erase, 3 no operation |
| cmd_sector | input | SECW | First 512-byte sector |
| cmd_count | input | CNTW | Number of sectors |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program byte offered |
| wr_ready | output | 1 | Program byte taken |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Read byte taken when high with rd_valid |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The completion pulse of one command can fall in the same cycle as the acceptance of the next one, because done is raised in the first idle cycle and cmd_ready is already high there. The bench provokes this by holding a second read command valid while the first read drains. It then checks three things: done is seen together with cmd_ready and cmd_valid, busy rises on the next cycle, and the second frame carries the right address and data. A command offered in the middle of a program is also checked: it must leave both the frame log and cmd_ready untouched.

// File: rtl/nor_eng_pkg.sv
package nor_eng_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_HDR, S_WDAT, S_RDAT, S_POLL, S_WRDI, S_GAP, S_FIN
  } st_e;

  localparam int SEC_SHIFT = 9;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_READ  = 8'h13;
  localparam logic [7:0] OPC_PROG  = 8'h12;
  localparam logic [7:0] OPC_ERASE = 8'hDC;
  localparam logic [7:0] FILL      = 8'hFF;
endpackage

// File: rtl/nor_byte_shifter.sv
module nor_byte_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  output logic       active,
  output logic       done,
  output logic [7:0] rx,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  logic [7:0] sr;
  logic [2:0] bitn;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      done   <= 1'b0;
      sck    <= 1'b0;
      sr     <= 8'hFF;
      bitn   <= '0;
      rx     <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        sr     <= tx;
        bitn   <= '0;
      end else if (active) begin
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            sr   <= {sr[6:0], 1'b1};
            bitn <= bitn + 3'd1;
          end
        end
      end
    end
  end

  assign mosi = sr[7];

  AST_DONE_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
    done |-> (!sck && !active)); // R2
endmodule

// File: rtl/nor_seq.sv
module nor_seq
  import nor_eng_pkg::*;
#(
  parameter int SECW        = 23,
  parameter int CNTW        = 12,
  parameter int ERASE_SHIFT = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic [SECW-1:0] cmd_sector,
  input  logic [CNTW-1:0] cmd_count,
  input  logic [7:0]      wr_data,
  input  logic            wr_valid,
  output logic            wr_ready,
  output logic [7:0]      rd_data,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic            busy,
  output logic            done,
  output logic            cs_n,
  output logic            sh_start,
  output logic [7:0]      sh_tx,
  input  logic            sh_active,
  input  logic            sh_done,
  input  logic [7:0]      sh_rx
);
  localparam int AW = SECW + SEC_SHIFT;

  st_e          st, gap_to;
  op_e          op;
  logic [AW-1:0] addr;
  logic [AW:0]   end_a;
  logic [39:0]   hdr;
  logic [2:0]    idx;
  logic          want, free;
  logic [AW-1:0] start_a;
  logic [SECW:0] sec_end;
  logic [31:0]   addr32;
  logic [7:0]    frame_opc;

  assign start_a   = {cmd_sector, {SEC_SHIFT{1'b0}}};
  assign sec_end   = {1'b0, cmd_sector} + (SECW+1)'(cmd_count);
  assign addr32    = 32'(addr);
  assign frame_opc = (op == OP_PROG) ? OPC_PROG : OPC_ERASE;
  assign free      = !sh_active && !sh_done;
  assign sh_start  = want && free;
  assign wr_ready  = (st == S_WDAT) && free;
  assign cmd_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);

  always_comb begin
    want  = 1'b0;
    sh_tx = FILL;
    case (st)
      S_WREN: begin want = 1'b1; sh_tx = OPC_WREN; end
      S_WRDI: begin want = 1'b1; sh_tx = OPC_WRDI; end
      S_HDR:  begin want = 1'b1; sh_tx = hdr[39:32]; end
      S_POLL: begin want = 1'b1; sh_tx = (idx == 3'd0) ? OPC_RDSR : FILL; end
      S_WDAT: begin want = wr_valid; sh_tx = wr_data; end
      S_RDAT: begin want = !rd_valid || rd_ready; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      gap_to   <= S_IDLE;
      op       <= OP_READ;
      addr     <= '0;
      end_a    <= '0;
      hdr      <= '0;
      idx      <= '0;
      done     <= 1'b0;
      cs_n     <= 1'b1;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      done <= (st == S_FIN);
      cs_n <= (st == S_IDLE) || (st == S_GAP) || (st == S_FIN);
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op    <= op_e'(cmd_op);
          addr  <= start_a;
          end_a <= {sec_end, {SEC_SHIFT{1'b0}}};
          idx   <= '0;
          if (cmd_count == '0 || op_e'(cmd_op) == OP_NONE) st <= S_FIN;
          else if (op_e'(cmd_op) == OP_READ) begin
            hdr <= {OPC_READ, 32'(start_a)};
            st  <= S_HDR;
          end else st <= S_WREN;
        end
        S_WREN: if (sh_done) begin st <= S_GAP; gap_to <= S_HDR; end
        S_HDR: if (sh_done) begin
          hdr <= {hdr[31:0], 8'h00};
          idx <= idx + 3'd1;
          if (idx == 3'd4) begin
            case (op)
              OP_READ: st <= S_RDAT;
              OP_PROG: st <= S_WDAT;
              default: begin
                addr   <= addr + (AW'(1) << ERASE_SHIFT);
                st     <= S_GAP;
                gap_to <= S_POLL;
              end
            endcase
          end
        end
        S_WDAT: if (sh_done) begin
          addr <= addr + AW'(1);
          if (addr[SEC_SHIFT-1:0] == '1) begin st <= S_GAP; gap_to <= S_POLL; end
        end
        S_RDAT: if (sh_done) begin
          rd_data  <= sh_rx;
          rd_valid <= 1'b1;
          addr     <= addr + AW'(1);
          if (({1'b0, addr} + (AW+1)'(1)) == end_a) begin st <= S_GAP; gap_to <= S_FIN; end
        end
        S_POLL: if (sh_done) begin
          idx <= idx + 3'd1;
          if (idx == 3'd1) begin
            st <= S_GAP;
            if (sh_rx[0])                  gap_to <= S_POLL;
            else if ({1'b0, addr} < end_a) gap_to <= S_HDR;
            else                           gap_to <= S_WRDI;
          end
        end
        S_WRDI: if (sh_done) begin st <= S_GAP; gap_to <= S_FIN; end
        S_GAP: begin
          st  <= gap_to;
          idx <= '0;
          if (gap_to == S_HDR) hdr <= {frame_opc, addr32};
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R5
  AST_RD_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    ((st == S_RDAT) && sh_done) |-> !rd_valid); // R5
  AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |-> !cs_n); // R6
  AST_EMPTY_CMD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && (cmd_count == '0)) |-> ##2 done); // R11
endmodule

// File: rtl/nor_sector_engine.sv
module nor_sector_engine #(
  parameter int SECW        = 23,
  parameter int CNTW        = 12,
  parameter int ERASE_SHIFT = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic [SECW-1:0] cmd_sector,
  input  logic [CNTW-1:0] cmd_count,
  input  logic [7:0]      wr_data,
  input  logic            wr_valid,
  output logic            wr_ready,
  output logic [7:0]      rd_data,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic            busy,
  output logic            done,
  output logic            spi_cs_n,
  output logic            spi_sck,
  output logic            spi_mosi,
  input  logic            spi_miso
);
  logic       sh_start, sh_active, sh_done;
  logic [7:0] sh_tx, sh_rx;

  nor_seq #(.SECW(SECW), .CNTW(CNTW), .ERASE_SHIFT(ERASE_SHIFT)) u_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .cmd_count(cmd_count),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .busy(busy), .done(done), .cs_n(spi_cs_n),
    .sh_start(sh_start), .sh_tx(sh_tx), .sh_active(sh_active),
    .sh_done(sh_done), .sh_rx(sh_rx)
  );

  nor_byte_shifter u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .tx(sh_tx),
    .active(sh_active), .done(sh_done), .rx(sh_rx),
    .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
  );

  AST_SCK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> !spi_cs_n); // R2
endmodule

// File: tb/nor_sector_engine_bench.sv
`timescale 1ns/1ps
module nor_sector_engine_bench;
  localparam int SECW = 23;
  localparam int CNTW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic            cmd_valid = 0, cmd_ready;
  logic [1:0]      cmd_op = 0;
  logic [SECW-1:0] cmd_sector = 0;
  logic [CNTW-1:0] cmd_count = 0;
  logic [7:0]      wr_data = 0;
  logic            wr_valid = 0, wr_ready;
  logic [7:0]      rd_data;
  logic            rd_valid, rd_ready = 1;
  logic            busy, done, spi_cs_n, spi_sck, spi_mosi;
  logic            spi_miso = 1'b1;

  nor_sector_engine #(.SECW(SECW), .CNTW(CNTW)) u_nor_sector_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sector(cmd_sector), .cmd_count(cmd_count),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .busy(busy), .done(done), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[16:9] ^ 8'h3C;
  endfunction

  // Behavioural flash model
  int          bitc = 0, bytec = 0, wip_cfg = 0, wip_left = 0, mdl_err = 0, fcnt = 0;
  logic [7:0]  isr = 8'hFF, osr = 8'hFF, fop = 8'h00;
  logic [31:0] fadr = 0, raddr = 0;
  bit          wel = 0;
  logic [7:0]  lg_op [64];
  logic [31:0] lg_adr [64];
  int          lg_len [64];

  always @(negedge spi_cs_n) begin bitc = 0; bytec = 0; osr = 8'hFF; end

  always @(posedge spi_sck) begin
    logic [31:0] nf;
    if (spi_cs_n) mdl_err++;
    isr = {isr[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin
      bitc = 0;
      if (bytec == 0) begin
        fop = isr;
        if (fop == 8'h05) begin
          osr = (wip_left > 0) ? 8'h01 : 8'h00;
          if (wip_left > 0) wip_left--;
        end
      end else if (bytec <= 4) begin
        nf = {fadr[23:0], isr};
        fadr = nf;
        if (bytec == 4 && fop == 8'h13) begin raddr = nf; osr = pat(nf); end
      end else begin
        if (fop == 8'h13) begin
          if (isr != 8'hFF) mdl_err++;
          raddr++;
          osr = pat(raddr);
        end
        if (fop == 8'h12 && isr != pat(fadr + 32'(bytec - 5))) mdl_err++;
      end
      bytec++;
    end
  end

  always @(negedge spi_sck) begin spi_miso = osr[7]; osr = {osr[6:0], 1'b1}; end

  always @(posedge spi_cs_n) begin
    if (bytec > 0) begin
      if (bitc != 0) mdl_err++;
      if (fcnt < 64) begin lg_op[fcnt] = fop; lg_adr[fcnt] = fadr; lg_len[fcnt] = bytec; end
      fcnt++;
      if (fop == 8'h12 || fop == 8'hDC) begin
        if (!wel) mdl_err++;
        wip_left = wip_cfg;
      end
      if (fop == 8'h06) wel = 1;
      if (fop == 8'h04) wel = 0;
      bytec = 0;
    end
  end

  // Helpers
  int ei;
  task automatic exp_frame(input string req, input logic [7:0] op, input logic [31:0] adr, input int len);
    if (ei < 64) begin
      check(req, "frame opcode", lg_op[ei], op);
      if (len >= 5) check("R2", "frame address", lg_adr[ei], adr);
      check(req, "frame length", lg_len[ei], len);
    end
    ei++;
  endtask

  task automatic issue(input logic [1:0] op, input int sec, input int cnt);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_sector = SECW'(sec); cmd_count = CNTW'(cnt);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done(input string req);
    int cyc = 0;
    while (!done && cyc < 60000) begin @(negedge clk); cyc++; end
    check(req, "done seen", done, 1);
    check(req, "busy low at done", busy, 0);
    @(negedge clk);
    check(req, "done one cycle", done, 0);
  endtask

  task automatic t_reset;
    check("R1", "cs_n", spi_cs_n, 1);
    check("R1", "sck", spi_sck, 0);
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "rd_valid", rd_valid, 0);
    check("R1", "cmd_ready", cmd_ready, 1);
  endtask

  task automatic t_read(input int sec, input int cnt, input bit stall);
    int got = 0, bad = 0, cyc = 0, rises;
    logic last;
    fcnt = 0; mdl_err = 0;
    issue(2'd0, sec, cnt);
    while (got < cnt * 512 && cyc < 80000) begin
      @(negedge clk); cyc++;
      if (stall && got == 100) begin
        rd_ready = 0; rises = 0; last = spi_sck;
        for (int i = 0; i < 60; i++) begin
          @(negedge clk);
          if (spi_sck && !last) rises++;
          last = spi_sck;
        end
        check("R5", "sck rises during stall <= 8", (rises <= 8), 1);
        check("R5", "cs low during stall", spi_cs_n, 0);
        check("R5", "byte held during stall", rd_valid, 1);
      end
      rd_ready = stall ? ((cyc % 7) != 0) : 1'b1;
      if (rd_valid && rd_ready) begin
        if (rd_data != pat(32'(sec * 512 + got))) bad++;
        got++;
      end
    end
    rd_ready = 1;
    wait_done("R10");
    check("R3", "bytes delivered", got, cnt * 512);
    check("R4", "read data mismatches", bad, 0);
    check("R4", "no extra byte after done", rd_valid, 0);
    check("R3", "frame count", fcnt, 1);
    check("R3", "mosi fill and model errors", mdl_err, 0);
    ei = 0;
    exp_frame("R3", 8'h13, 32'(sec * 512), 5 + cnt * 512);
  endtask

  task automatic exp_polls(input int polls);
    for (int p = 0; p <= polls; p++) exp_frame("R8", 8'h05, 0, 2);
  endtask

  task automatic t_prog(input int sec, input int cnt, input int polls);
    int k = 0, n = cnt * 512;
    fcnt = 0; mdl_err = 0; wip_cfg = polls;
    issue(2'd1, sec, cnt);
    fork
      begin
        while (k < n) begin
          @(negedge clk);
          wr_data = pat(32'(sec * 512 + k)); wr_valid = 1;
          if (wr_ready) k++;
        end
        @(negedge clk); wr_valid = 0;
      end
      begin
        repeat (3000) @(negedge clk);
        cmd_valid = 1; cmd_op = 2'd0; cmd_sector = 7; cmd_count = 1;
        for (int i = 0; i < 20; i++) begin
          @(negedge clk);
          check("R10", "cmd_ready low while busy", cmd_ready, 0);
        end
        cmd_valid = 0;
      end
    join
    wait_done("R10");
    check("R6", "program data and enable errors", mdl_err, 0);
    check("R8", "frame count", fcnt, 2 + cnt * (2 + polls));
    ei = 0;
    exp_frame("R6", 8'h06, 0, 1);
    for (int s = 0; s < cnt; s++) begin
      exp_frame("R6", 8'h12, 32'((sec + s) * 512), 517);
      exp_polls(polls);
    end
    exp_frame("R9", 8'h04, 0, 1);
  endtask

  task automatic t_erase(input int sec, input int cnt, input int polls);
    longint a, stop;
    int blocks = 0;
    fcnt = 0; mdl_err = 0; wip_cfg = polls;
    issue(2'd2, sec, cnt);
    wait_done("R10");
    check("R7", "erase enable errors", mdl_err, 0);
    ei = 0;
    exp_frame("R7", 8'h06, 0, 1);
    a = longint'(sec) * 512; stop = longint'(sec + cnt) * 512;
    while (a < stop) begin
      exp_frame("R7", 8'hDC, 32'(a), 5);
      exp_polls(polls);
      a += 262144; blocks++;
    end
    exp_frame("R9", 8'h04, 0, 1);
    check("R7", "frame count", fcnt, 2 + blocks * (2 + polls));
  endtask

  task automatic t_empty;
    fcnt = 0;
    issue(2'd1, 5, 0);
    wait_done("R11");
    check("R11", "no frame for count 0", fcnt, 0);
    issue(2'd3, 9, 4);
    wait_done("R11");
    check("R11", "no frame for op 3", fcnt, 0);
  endtask

  task automatic t_b2b;
    int got = 0, bad = 0, cyc = 0;
    fcnt = 0; mdl_err = 0;
    issue(2'd0, 40, 1);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd0; cmd_sector = 41; cmd_count = 1;
    while (!done && cyc < 30000) begin @(negedge clk); cyc++; end
    check("R10", "done with next command", done, 1);
    check("R10", "cmd_ready in done cycle", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 0;
    check("R10", "busy after back-to-back accept", busy, 1);
    cyc = 0;
    while (got < 512 && cyc < 30000) begin
      @(negedge clk); cyc++;
      if (rd_valid && rd_ready) begin
        if (rd_data != pat(32'(41 * 512 + got))) bad++;
        got++;
      end
    end
    wait_done("R10");
    check("R4", "second read data mismatches", bad, 0);
    check("R3", "two frames", fcnt, 2);
    ei = 1;
    exp_frame("R3", 8'h13, 32'(41 * 512), 517);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_read(3, 2, 1'b0);
    t_read(1000, 1, 1'b1);
    t_prog(20, 2, 3);
    t_erase(3, 1100, 2);
    t_erase(512, 1, 0);
    t_empty();
    t_b2b();
    summary();
    $finish;
  end
endmodule